// File: doc/BRIEF.md
# Framed Voice-Channel Serial Port (PCM and ADPCM)

This block moves one voice channel as bit-serial data between a codec and an ADPCM transcoder. A single variable-rate bit clock is shared by both directions. The transmit and receive directions each have their own frame sync, and each sync marks the most significant bit of its frame. In the transmit direction the block sends an 8-bit PCM word and a 4-bit ADPCM code. In the receive direction it collects an 8-bit PCM word and a 4-bit ADPCM code. All words travel MSB first.

The core writes transmit words into holding registers with a load strobe. When the receive side has collected a whole frame, it hands both received words to the core with a one-cycle valid strobe. The transmit ADPCM line is open drain and is modelled as a pad level plus an output enable. The enable is high only while a 0 is driven, and it drops while power-down is asserted.

All serial pins are treated as slow signals in the system clock domain. The bit clock and the serial inputs pass through a synchronizer. Edge detectors then produce one-cycle rise and fall events. Outputs change on rising bit-clock edges and inputs are sampled on falling edges.

Top module: `pcm_adpcm_sif`

## Requirements
- R1: While reset is high and after it is released, the outputs rest at tx_pcm_o=1, tx_pcm_oe=0, tx_adp_o=1, tx_adp_oe=0, rx_valid_o=0, rx_pcm_o=0 and rx_adp_o=0. They stay there until the first frame starts.
- R2: A transmit frame starts at a bit-clock rising edge where tx_sync_i is 1 and was 0 at the previous rising edge. From that slot on, tx_pcm_o carries bit 7 first, then bits 6 down to 0, one per rising edge, and tx_pcm_oe is 1 for exactly those 8 slots.
- R3: In the first 4 slots of a transmit frame, the ADPCM code goes out on the open-drain line MSB first. For a 0 bit, tx_adp_oe=1 and tx_adp_o=0. For a 1 bit, tx_adp_oe=0 and tx_adp_o=1. tx_adp_oe=1 never occurs together with tx_adp_o=1.
- R4: After the last bit of a lane, that lane is released until the next frame start. For PCM this means tx_pcm_oe=0 and tx_pcm_o=1. For ADPCM this means tx_adp_oe=0 and tx_adp_o=1.
- R5: While pwr_down_i is 1, tx_adp_oe is 0 and tx_adp_o is 1 from the next clock onward. Slot counting goes on, so the lane resumes mid-frame when power-down drops.
- R6: A receive frame starts at a rising edge where rx_sync_i is 1 and was 0 at the previous rising edge. The first falling edge after that start captures bit 7 of rx_pcm_i and bit 3 of rx_adp_i. The next falling edges capture the lower bits: PCM through its 8th fall and ADPCM through its 4th.
- R7: After the 8th captured PCM bit, rx_valid_o is 1 for exactly one clock and rx_pcm_o and rx_adp_o show the frame's words. At all other times both words hold their value.
- R8: If a new frame start arrives while a word is still in flight, both the transmitter and the receiver restart at bit 7. The partial receive word is discarded and produces no valid strobe.
- R9: At the lowest bit clock a frame holds only 8 slots. Frames that follow each other back to back still deliver every word complete in both directions.
- R10: The words on tx_pcm_i and tx_adp_i are captured when tx_load_i is 1. They are sent in the next transmit frame that starts after the capture. A load during a frame does not change the frame already in flight.
- R11: A sync held at 1 for several slots starts only one frame, at its first rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk_i | input | 1 | Shared serial bit clock |
| tx_sync_i | input | 1 | Transmit frame sync, marks the MSB slot |
| rx_sync_i | input | 1 | Receive frame sync, marks the MSB slot |
| pwr_down_i | input | 1 | Power-down; floats the open-drain ADPCM line |
| tx_load_i | input | 1 | Strobe capturing the transmit words |
| tx_pcm_i | input | PCM_W | Transmit PCM word |
| tx_adp_i | input | ADP_W | Transmit ADPCM code |
| tx_pcm_o | output | 1 | Serial transmit PCM data, 1 when released |
| tx_pcm_oe | output | 1 | Tri-state enable for tx_pcm_o |
| tx_adp_o | output | 1 | Level of the open-drain ADPCM line with pull-up |
| tx_adp_oe | output | 1 | Pull-down enable of the open-drain ADPCM line |
| rx_pcm_i | input | 1 | Serial receive PCM data |
| rx_adp_i | input | 1 | Serial receive ADPCM data |
| rx_pcm_o | output | PCM_W | Received PCM word |
| rx_adp_o | output | ADP_W | Received ADPCM code |
| rx_valid_o | output | 1 | One-cycle strobe for a complete received frame |

## Verification
A slot counter that is off by one shows up within one bit slot. The transmit line then carries a bit of the wrong weight, or its enable stays high for a ninth slot, and the per-slot comparison of both transmit lines catches it. A receive shifter that misses a falling edge, or that fails to restart on a sync, shows up at the end of the frame. The result is a wrong word, or a valid strobe where none is expected, because the partial word from a restarted frame must never appear. A stuck power-down gate is seen on the first slot after power-down rises that holds a 0 bit.

// File: rtl/pcm_sif_pkg.sv
package pcm_sif_pkg;

  // Default geometry of the voice channel.
  localparam int PCM_BITS   = 8;
  localparam int ADP_BITS   = 4;
  localparam int SYNC_DEPTH = 2;

  // Indices into the vector of synchronized serial pins.
  localparam int PIN_BCLK  = 4;
  localparam int PIN_TXS   = 3;
  localparam int PIN_RXS   = 2;
  localparam int PIN_RPCM  = 1;
  localparam int PIN_RADP  = 0;
  localparam int PIN_COUNT = 5;

  // Events derived from the bit clock.
  typedef struct packed {
    logic rise;
    logic fall;
  } bclk_evt_t;

endpackage

// File: rtl/sif_sync.sv
module sif_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage[i] <= '0;
        else     stage[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage[i] <= '0;
        else     stage[i] <= stage[i-1];
      end
    end
  end

  assign q = stage[STAGES-1];

endmodule

// File: rtl/sif_framer.sv
module sif_framer (
  input  logic clk,
  input  logic rst,
  input  logic rise,
  input  logic sync,
  output logic start
);

  // Sync level seen at the previous rising bit-clock edge.
  logic sync_at_rise;

  always_ff @(posedge clk) begin
    if (rst)       sync_at_rise <= 1'b0;
    else if (rise) sync_at_rise <= sync;
  end

  assign start = rise & sync & ~sync_at_rise;

endmodule

// File: rtl/sif_tx.sv
module sif_tx #(
  parameter int W          = 8,
  parameter bit OPEN_DRAIN = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         rise,
  input  logic         start,
  input  logic         quiet,
  input  logic [W-1:0] word,
  output logic         pad_o,
  output logic         pad_oe
);

  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  shreg;
  logic [CW-1:0] left;
  logic          active;
  logic          cur_bit;
  logic          drive;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg  <= '0;
      left   <= '0;
      active <= 1'b0;
    end else if (start) begin
      shreg  <= word;
      left   <= CW'(W);
      active <= 1'b1;
    end else if (rise && active) begin
      shreg <= shreg << 1;
      left  <= left - 1'b1;
      if (left == CW'(1)) active <= 1'b0;
    end
  end

  assign cur_bit = shreg[W-1];
  assign drive   = active & ~quiet;

  if (OPEN_DRAIN) begin : g_od
    always_ff @(posedge clk) begin
      if (rst) begin
        pad_o  <= 1'b1;
        pad_oe <= 1'b0;
      end else begin
        pad_o  <= drive ? cur_bit : 1'b1;
        pad_oe <= drive & ~cur_bit;
      end
    end
  end else begin : g_pp
    always_ff @(posedge clk) begin
      if (rst) begin
        pad_o  <= 1'b1;
        pad_oe <= 1'b0;
      end else begin
        pad_o  <= drive ? cur_bit : 1'b1;
        pad_oe <= drive;
      end
    end
  end

endmodule

// File: rtl/sif_rx.sv
module sif_rx #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         fall,
  input  logic         din,
  output logic [W-1:0] word_o,
  output logic         done_o
);

  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  shreg;
  logic [CW-1:0] left;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg  <= '0;
      left   <= '0;
      word_o <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start) begin
        left <= CW'(W);
      end else if (fall && left != '0) begin
        shreg <= {shreg[W-2:0], din};
        left  <= left - 1'b1;
        if (left == CW'(1)) begin
          word_o <= {shreg[W-2:0], din};
          done_o <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/pcm_adpcm_sif.sv
module pcm_adpcm_sif
  import pcm_sif_pkg::*;
#(
  parameter int PCM_W       = PCM_BITS,
  parameter int ADP_W       = ADP_BITS,
  parameter int SYNC_STAGES = SYNC_DEPTH
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bclk_i,
  input  logic             tx_sync_i,
  input  logic             rx_sync_i,
  input  logic             pwr_down_i,
  input  logic             tx_load_i,
  input  logic [PCM_W-1:0] tx_pcm_i,
  input  logic [ADP_W-1:0] tx_adp_i,
  output logic             tx_pcm_o,
  output logic             tx_pcm_oe,
  output logic             tx_adp_o,
  output logic             tx_adp_oe,
  input  logic             rx_pcm_i,
  input  logic             rx_adp_i,
  output logic [PCM_W-1:0] rx_pcm_o,
  output logic [ADP_W-1:0] rx_adp_o,
  output logic             rx_valid_o
);

  logic [PIN_COUNT-1:0] pins_s;
  logic                 bclk_prev;
  bclk_evt_t            evt;
  logic                 tx_start;
  logic                 rx_start;
  logic [PCM_W-1:0]     hold_pcm;
  logic [ADP_W-1:0]     hold_adp;
  logic [PCM_W-1:0]     rx_pcm_word;
  logic [ADP_W-1:0]     rx_adp_word;
  logic                 rx_pcm_done;
  logic                 rx_adp_done;
  logic                 adp_fresh;

  sif_sync #(.W(PIN_COUNT), .STAGES(SYNC_STAGES)) i_sync (
    .clk (clk),
    .rst (rst),
    .d   ({bclk_i, tx_sync_i, rx_sync_i, rx_pcm_i, rx_adp_i}),
    .q   (pins_s)
  );

  always_ff @(posedge clk) begin
    if (rst) bclk_prev <= 1'b0;
    else     bclk_prev <= pins_s[PIN_BCLK];
  end

  assign evt.rise = pins_s[PIN_BCLK] & ~bclk_prev;
  assign evt.fall = ~pins_s[PIN_BCLK] & bclk_prev;

  sif_framer i_tx_framer (
    .clk   (clk),
    .rst   (rst),
    .rise  (evt.rise),
    .sync  (pins_s[PIN_TXS]),
    .start (tx_start)
  );

  sif_framer i_rx_framer (
    .clk   (clk),
    .rst   (rst),
    .rise  (evt.rise),
    .sync  (pins_s[PIN_RXS]),
    .start (rx_start)
  );

  // Transmit holding registers written by the core.
  always_ff @(posedge clk) begin
    if (rst) begin
      hold_pcm <= '0;
      hold_adp <= '0;
    end else if (tx_load_i) begin
      hold_pcm <= tx_pcm_i;
      hold_adp <= tx_adp_i;
    end
  end

  sif_tx #(.W(PCM_W), .OPEN_DRAIN(1'b0)) i_tx_pcm (
    .clk    (clk),
    .rst    (rst),
    .rise   (evt.rise),
    .start  (tx_start),
    .quiet  (1'b0),
    .word   (hold_pcm),
    .pad_o  (tx_pcm_o),
    .pad_oe (tx_pcm_oe)
  );

  sif_tx #(.W(ADP_W), .OPEN_DRAIN(1'b1)) i_tx_adp (
    .clk    (clk),
    .rst    (rst),
    .rise   (evt.rise),
    .start  (tx_start),
    .quiet  (pwr_down_i),
    .word   (hold_adp),
    .pad_o  (tx_adp_o),
    .pad_oe (tx_adp_oe)
  );

  sif_rx #(.W(PCM_W)) i_rx_pcm (
    .clk    (clk),
    .rst    (rst),
    .start  (rx_start),
    .fall   (evt.fall),
    .din    (pins_s[PIN_RPCM]),
    .word_o (rx_pcm_word),
    .done_o (rx_pcm_done)
  );

  sif_rx #(.W(ADP_W)) i_rx_adp (
    .clk    (clk),
    .rst    (rst),
    .start  (rx_start),
    .fall   (evt.fall),
    .din    (pins_s[PIN_RADP]),
    .word_o (rx_adp_word),
    .done_o (rx_adp_done)
  );

  // The code must belong to the frame whose PCM word completes now.
  always_ff @(posedge clk) begin
    if (rst)              adp_fresh <= 1'b0;
    else if (rx_start)    adp_fresh <= 1'b0;
    else if (rx_adp_done) adp_fresh <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_pcm_o   <= '0;
      rx_adp_o   <= '0;
      rx_valid_o <= 1'b0;
    end else begin
      rx_valid_o <= rx_pcm_done & adp_fresh;
      if (rx_pcm_done && adp_fresh) begin
        rx_pcm_o <= rx_pcm_word;
        rx_adp_o <= rx_adp_word;
      end
    end
  end

endmodule

// File: rtl/sif_checker.sv
module sif_checker #(
  parameter int PCM_W = 8,
  parameter int ADP_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             pwr_down_i,
  input logic             tx_pcm_o,
  input logic             tx_pcm_oe,
  input logic             tx_adp_o,
  input logic             tx_adp_oe,
  input logic [PCM_W-1:0] rx_pcm_o,
  input logic [ADP_W-1:0] rx_adp_o,
  input logic             rx_valid_o
);

  AST_OD_LOW_ONLY: assert property (@(posedge clk) disable iff (rst)
    tx_adp_oe |-> !tx_adp_o);  // R3

  AST_PCM_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    !tx_pcm_oe |-> tx_pcm_o);  // R4

  AST_PD_FLOAT: assert property (@(posedge clk) disable iff (rst)
    pwr_down_i |=> !tx_adp_oe);  // R5

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    rx_valid_o |=> !rx_valid_o);  // R7

  AST_RX_WORDS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rx_valid_o |-> ($stable(rx_pcm_o) && $stable(rx_adp_o)));  // R7

endmodule

bind pcm_adpcm_sif sif_checker #(.PCM_W(PCM_W), .ADP_W(ADP_W)) i_sif_checker (
  .clk        (clk),
  .rst        (rst),
  .pwr_down_i (pwr_down_i),
  .tx_pcm_o   (tx_pcm_o),
  .tx_pcm_oe  (tx_pcm_oe),
  .tx_adp_o   (tx_adp_o),
  .tx_adp_oe  (tx_adp_oe),
  .rx_pcm_o   (rx_pcm_o),
  .rx_adp_o   (rx_adp_o),
  .rx_valid_o (rx_valid_o)
);

// File: tb/test_pcm_adpcm_sif.sv
module test_pcm_adpcm_sif;

  localparam int H = 10;  // clocks per bit-clock half period

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst = 1'b1;
  logic       bclk = 1'b0, tx_sync = 1'b0, rx_sync = 1'b0, pd = 1'b0;
  logic       tx_load = 1'b0;
  logic [7:0] tx_pcm = '0;
  logic [3:0] tx_adp = '0;
  logic       tx_pcm_o, tx_pcm_oe, tx_adp_o, tx_adp_oe;
  logic       rx_pcm = 1'b0, rx_adp = 1'b0;
  logic [7:0] rx_pcm_o;
  logic [3:0] rx_adp_o;
  logic       rx_valid_o;

  pcm_adpcm_sif i_pcm_adpcm_sif (
    .clk(clk), .rst(rst), .bclk_i(bclk), .tx_sync_i(tx_sync), .rx_sync_i(rx_sync),
    .pwr_down_i(pd), .tx_load_i(tx_load), .tx_pcm_i(tx_pcm), .tx_adp_i(tx_adp),
    .tx_pcm_o(tx_pcm_o), .tx_pcm_oe(tx_pcm_oe), .tx_adp_o(tx_adp_o), .tx_adp_oe(tx_adp_oe),
    .rx_pcm_i(rx_pcm), .rx_adp_i(rx_adp), .rx_pcm_o(rx_pcm_o), .rx_adp_o(rx_adp_o),
    .rx_valid_o(rx_valid_o)
  );

  int    n_cmp = 0, n_bad = 0;
  bit    finished = 0;
  string tag = "R1";

  logic [11:0] exp_q[$];  // {pcm, adp} expected from the receiver

  // Bench model of the protocol.
  logic [7:0] hold_p = '0, cur_p = '0, acc_p = '0;
  logic [3:0] hold_a = '0, cur_a = '0, acc_a = '0;
  int         tx_idx = 99, rx_idx = 99;
  logic       tx_prev = 1'b0, rx_prev = 1'b0;

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load(logic [7:0] p, logic [3:0] a);
    tx_load = 1'b1; tx_pcm = p; tx_adp = a;
    hold_p = p; hold_a = a;
    @(negedge clk);
    tx_load = 1'b0;
  endtask

  // One bit slot: setup, rising edge, high phase, falling edge, low phase.
  task automatic slot(logic st, logic sr, logic dp, logic da);
    logic ep, epo, ea, eao, drv;
    tx_sync = st; rx_sync = sr; rx_pcm = dp; rx_adp = da;
    repeat (3) @(negedge clk);
    bclk = 1'b1;
    if (st && !tx_prev) begin tx_idx = 0; cur_p = hold_p; cur_a = hold_a; end
    tx_prev = st;
    if (sr && !rx_prev) rx_idx = 0;
    rx_prev = sr;
    repeat (H) @(negedge clk);
    epo = (tx_idx < 8);
    ep  = epo ? cur_p[7 - tx_idx] : 1'b1;
    drv = (tx_idx < 4) && !pd;
    ea  = drv ? cur_a[3 - tx_idx] : 1'b1;
    eao = drv && !ea;
    chk($sformatf("%s pcm-lane %s", (tx_idx < 8) ? "R2" : "R4", tag),
        {14'd0, tx_pcm_oe, tx_pcm_o}, {14'd0, epo, ep});
    chk($sformatf("%s adp-lane %s", pd ? "R5" : ((tx_idx < 4) ? "R3" : "R4"), tag),
        {14'd0, tx_adp_oe, tx_adp_o}, {14'd0, eao, ea});
    bclk = 1'b0;
    if (rx_idx < 8) begin
      if (rx_idx < 4) acc_a = {acc_a[2:0], da};
      acc_p = {acc_p[6:0], dp};
      rx_idx++;
      if (rx_idx == 8) exp_q.push_back({acc_p, acc_a});
    end
    if (tx_idx < 8) tx_idx++;
    repeat (H - 3) @(negedge clk);
  endtask

  // One frame on both directions; sync held for sync_len slots.
  task automatic frame(logic [7:0] rp, logic [3:0] ra, int nslots, int sync_len,
                       int load_at, logic [7:0] lp, logic [3:0] la);
    for (int s = 0; s < nslots; s++) begin
      if (s == load_at) load(lp, la);
      slot(s < sync_len, s < sync_len, (s < 8) ? rp[7 - s] : 1'b0, (s < 4) ? ra[3 - s] : 1'b0);
    end
  endtask

  // Scoreboard monitor for received words.
  always @(negedge clk) begin
    if (!rst && rx_valid_o) begin
      if (exp_q.size() == 0) begin
        chk($sformatf("R7 R8 unexpected valid %s", tag), {4'd0, rx_pcm_o, rx_adp_o}, 16'hFFFF);
      end else begin
        logic [11:0] e;
        e = exp_q.pop_front();
        chk($sformatf("R6 R7 rx words %s", tag), {4'd0, rx_pcm_o, rx_adp_o}, {4'd0, e});
      end
    end
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL R7 watchdog actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    // R1: reset state, during and after reset
    chk("R1 reset tx", {12'd0, tx_pcm_o, tx_pcm_oe, tx_adp_o, tx_adp_oe}, 16'b1010);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    chk("R1 idle tx", {12'd0, tx_pcm_o, tx_pcm_oe, tx_adp_o, tx_adp_oe}, 16'b1010);
    chk("R1 idle rx", {3'd0, rx_valid_o, rx_pcm_o, rx_adp_o}, 16'd0);

    // R2 R3 R4 R6 R7 R10: basic frame with release slots
    tag = "R10 basic";
    load(8'hA5, 4'h6);
    frame(8'h3C, 4'h9, 12, 1, -1, 8'h00, 4'h0);
    frame(8'hC1, 4'h2, 12, 1, -1, 8'h00, 4'h0);

    // R10: load mid-frame does not disturb the frame in flight
    tag = "R10 midload";
    frame(8'h0F, 4'hE, 12, 1, 3, 8'h5A, 4'h1);
    frame(8'hF0, 4'h7, 12, 1, -1, 8'h00, 4'h0);

    // R9: back-to-back 8-slot frames at the slowest rate
    tag = "R9 minrate";
    load(8'h81, 4'h0);
    frame(8'h96, 4'hB, 8, 1, -1, 8'h00, 4'h0);
    load(8'h7E, 4'hF);
    frame(8'h69, 4'h4, 8, 1, -1, 8'h00, 4'h0);
    load(8'h00, 4'h5);
    frame(8'hFF, 4'hA, 8, 1, -1, 8'h00, 4'h0);

    // R5: power-down during a frame
    tag = "R5 pwrdn";
    load(8'h55, 4'h0);
    pd = 1'b1;
    frame(8'h24, 4'h3, 9, 1, -1, 8'h00, 4'h0);
    load(8'h33, 4'h2);
    frame(8'h42, 4'hC, 2, 1, -1, 8'h00, 4'h0);
    pd = 1'b0;
    frame(8'h00, 4'h0, 8, 0, -1, 8'h00, 4'h0);

    // R11: sync held for three slots starts a single frame
    tag = "R11 longsync";
    load(8'hB2, 4'h8);
    frame(8'hD3, 4'h1, 12, 3, -1, 8'h00, 4'h0);

    // R8: restart mid-word; partial receive word discarded
    tag = "R8 restart";
    load(8'h1E, 4'hD);
    slot(1'b1, 1'b1, 1'b1, 1'b1);
    slot(1'b0, 1'b0, 1'b0, 1'b1);
    slot(1'b0, 1'b0, 1'b1, 1'b0);
    slot(1'b0, 1'b0, 1'b1, 1'b1);
    frame(8'h4B, 4'h6, 12, 1, -1, 8'h00, 4'h0);

    repeat (20) @(negedge clk);
    chk("R7 R8 pending words", 16'(exp_q.size()), 16'd0);
    finished = 1;
    summary();
    $finish;
  end

endmodule